// File: doc/BRIEF.md
# Program Memory Lock Controller

This block decides which accesses to on-chip program memory are allowed, given the state of three non-volatile lock bits. Each lock bit is either left blank or programmed. The more bits are programmed, the more the block refuses: first the reading of internal code by table reads that run from external memory, and further writes to the flash; then verification readback; and at the top level, program execution from external memory. The block takes one request flag for each of these access kinds and returns one grant flag for each. A grant is the request, allowed through only when the current protection level permits it.

The block also supplies the external-access level that the rest of the chip uses to choose between internal and external program memory. With no lock bit programmed, this level follows the external-access pin directly. Once any lock bit is programmed, the block instead uses a copy of the pin that was captured while reset was asserted. Changes on the pin after reset then have no effect until the next reset. Before the first reset the captured copy is undefined.

The lock bits have no readback path. Their state can only be seen through the grants they withhold and through the source of the external-access level.

Top module: `prog_lock_ctrl`

## Requirements
- R1: With `lock_bits` = 3'b000, every grant equals its request in the same cycle, and `ea_effective` equals `ext_access_pin` in the same cycle.
- R2: With `lock_bits` = 3'b001 (bit 0 is the first lock bit; 1 means programmed), `grant_table_read` and `grant_program` stay low, while `grant_verify` and `grant_ext_exec` follow their requests.
- R3: While any lock bit is programmed, `ea_effective` equals the value `ext_access_pin` had on the last clock edge with `rst` high. Later changes of the pin have no effect on it.
- R4: With `lock_bits` = 3'b011, `grant_verify` is also held low, and `grant_ext_exec` still follows its request.
- R5: With `lock_bits` = 3'b111, all four grants are held low.
- R6: A combination outside the cumulative set takes the level of its highest programmed bit. With bit 2 set, all grants are low. With bit 1 set and bit 2 clear, only `grant_ext_exec` may be granted.
- R7: No grant is ever high while its own request is low.
- R8: A new reset recaptures the pin, so `ea_effective` under lock takes the value the pin held during the latest reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the external-access pin is captured while it is high |
| lock_bits | input | 3 | Lock bit states, bit 0 = first lock bit, 1 = programmed |
| ext_access_pin | input | 1 | Live external-access pin level |
| req_table_read | input | 1 | Table read from external code asking for an internal code byte |
| req_program | input | 1 | Flash programming request |
| req_verify | input | 1 | Verification readback request |
| req_ext_exec | input | 1 | External program execution request |
| grant_table_read | output | 1 | Table read permitted |
| grant_program | output | 1 | Programming permitted |
| grant_verify | output | 1 | Verification permitted |
| grant_ext_exec | output | 1 | External execution permitted |
| ea_effective | output | 1 | External-access level used by the chip |

## Verification
The bench walks every one of the eight lock combinations with all requests raised. A decoder that only recognised the cumulative patterns would then leak grants for the combinations with bit 2 or bit 1 set but a lower bit clear. Sparse request patterns catch a gate that grants without a request, or that mixes up which grant belongs to which request. Pin toggles after reset under lock expose a design that still passes the live pin through, and a second reset with the opposite pin value exposes a capture register that loads only once. With all bits clear, a pin toggle checked in the same cycle catches a design that registers the live path.

// File: rtl/prog_lock_pkg.sv
package prog_lock_pkg;

    localparam int LOCK_W = 3;
    localparam int REQ_N  = 4;

    // Request vector positions
    localparam int RQ_TABLE  = 0;
    localparam int RQ_PROG   = 1;
    localparam int RQ_VERIFY = 2;
    localparam int RQ_EXEC   = 3;

    typedef enum logic [1:0] {
        LVL_OPEN      = 2'd0,
        LVL_NO_WRITE  = 2'd1,
        LVL_NO_VERIFY = 2'd2,
        LVL_NO_EXT    = 2'd3
    } prot_level_e;

    typedef struct packed {
        logic             use_latched;
        logic [REQ_N-1:0] allow;
    } policy_t;

    // Highest programmed bit selects the level
    function automatic prot_level_e level_of(input logic [LOCK_W-1:0] lb);
        prot_level_e lvl;
        lvl = LVL_OPEN;
        for (int i = 0; i < LOCK_W; i++) begin
            if (lb[i]) lvl = prot_level_e'(2'(i + 1));
        end
        return lvl;
    endfunction

    function automatic policy_t policy_of(input prot_level_e lvl);
        policy_t p;
        p.use_latched       = (lvl != LVL_OPEN);
        p.allow             = '1;
        p.allow[RQ_TABLE]   = (lvl == LVL_OPEN);
        p.allow[RQ_PROG]    = (lvl == LVL_OPEN);
        p.allow[RQ_VERIFY]  = (lvl == LVL_OPEN) || (lvl == LVL_NO_WRITE);
        p.allow[RQ_EXEC]    = (lvl != LVL_NO_EXT);
        return p;
    endfunction

endpackage

// File: rtl/lock_level_decode.sv
module lock_level_decode
    import prog_lock_pkg::*;
(
    input  logic [LOCK_W-1:0] lock_bits,
    output policy_t           policy
);
    prot_level_e level;

    always_comb begin
        level  = level_of(lock_bits);
        policy = policy_of(level);
    end
endmodule

// File: rtl/ea_capture.sv
module ea_capture (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic use_latched,
    output logic ea_out
);
    logic captured;

    // Loaded only while reset is held; undefined until the first reset
    always_ff @(posedge clk) begin
        if (rst) captured <= pin;
    end

    assign ea_out = use_latched ? captured : pin;
endmodule

// File: rtl/access_gate.sv
module access_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] allow,
    output logic [N-1:0] grant
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign grant[g] = req[g] & allow[g];
    end
endmodule

// File: rtl/prog_lock_ctrl.sv
module prog_lock_ctrl
    import prog_lock_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LOCK_W-1:0] lock_bits,
    input  logic              ext_access_pin,
    input  logic              req_table_read,
    input  logic              req_program,
    input  logic              req_verify,
    input  logic              req_ext_exec,
    output logic              grant_table_read,
    output logic              grant_program,
    output logic              grant_verify,
    output logic              grant_ext_exec,
    output logic              ea_effective
);
    policy_t          policy;
    logic [REQ_N-1:0] req_vec;
    logic [REQ_N-1:0] grant_vec;

    always_comb begin
        req_vec            = '0;
        req_vec[RQ_TABLE]  = req_table_read;
        req_vec[RQ_PROG]   = req_program;
        req_vec[RQ_VERIFY] = req_verify;
        req_vec[RQ_EXEC]   = req_ext_exec;
    end

    lock_level_decode u_decode (
        .lock_bits (lock_bits),
        .policy    (policy)
    );

    access_gate #(.N(REQ_N)) u_gate (
        .req   (req_vec),
        .allow (policy.allow),
        .grant (grant_vec)
    );

    ea_capture u_ea (
        .clk         (clk),
        .rst         (rst),
        .pin         (ext_access_pin),
        .use_latched (policy.use_latched),
        .ea_out      (ea_effective)
    );

    assign grant_table_read = grant_vec[RQ_TABLE];
    assign grant_program    = grant_vec[RQ_PROG];
    assign grant_verify     = grant_vec[RQ_VERIFY];
    assign grant_ext_exec   = grant_vec[RQ_EXEC];
endmodule

// File: rtl/prog_lock_ctrl_chk.sv
module prog_lock_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] lock_bits,
    input logic       ext_access_pin,
    input logic       req_table_read,
    input logic       req_program,
    input logic       req_verify,
    input logic       req_ext_exec,
    input logic       grant_table_read,
    input logic       grant_program,
    input logic       grant_verify,
    input logic       grant_ext_exec,
    input logic       ea_effective
);
    assert_open_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (lock_bits == 3'b000) |->
            (grant_table_read == req_table_read) && (grant_program == req_program) &&
            (grant_verify == req_verify) && (grant_ext_exec == req_ext_exec) &&
            (ea_effective == ext_access_pin));

    assert_write_block_R2: assert property (@(posedge clk) disable iff (rst)
        (lock_bits != 3'b000) |-> !grant_table_read && !grant_program);

    assert_ea_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        ((lock_bits != 3'b000) && ($past(lock_bits) != 3'b000) && !$past(rst))
            |-> (ea_effective == $past(ea_effective)));

    assert_verify_block_R4: assert property (@(posedge clk) disable iff (rst)
        (lock_bits[1] || lock_bits[2]) |-> !grant_verify);

    assert_exec_block_R5: assert property (@(posedge clk) disable iff (rst)
        lock_bits[2] |-> !grant_ext_exec);

    assert_no_spurious_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (!req_table_read |-> !grant_table_read) and (!req_program |-> !grant_program) and
        (!req_verify |-> !grant_verify) and (!req_ext_exec |-> !grant_ext_exec));
endmodule

bind prog_lock_ctrl prog_lock_ctrl_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .lock_bits        (lock_bits),
    .ext_access_pin   (ext_access_pin),
    .req_table_read   (req_table_read),
    .req_program      (req_program),
    .req_verify       (req_verify),
    .req_ext_exec     (req_ext_exec),
    .grant_table_read (grant_table_read),
    .grant_program    (grant_program),
    .grant_verify     (grant_verify),
    .grant_ext_exec   (grant_ext_exec),
    .ea_effective     (ea_effective)
);

// File: tb/prog_lock_ctrl_test.sv
module prog_lock_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // vector: {req_id[3:0], lock[2:0], req[3:0], exp[3:0]}
    // req/exp bit order: [3]=ext_exec [2]=verify [1]=program [0]=table_read
    localparam logic [14:0] VEC [NVEC] = '{
        {4'd1, 3'b000, 4'hF, 4'hF},
        {4'd2, 3'b001, 4'hF, 4'hC},
        {4'd4, 3'b011, 4'hF, 4'h8},
        {4'd5, 3'b111, 4'hF, 4'h0},
        {4'd6, 3'b100, 4'hF, 4'h0},
        {4'd6, 3'b010, 4'hF, 4'h8},
        {4'd6, 3'b110, 4'hF, 4'h0},
        {4'd6, 3'b101, 4'hF, 4'h0},
        {4'd1, 3'b000, 4'h5, 4'h5},
        {4'd2, 3'b001, 4'hA, 4'h8},
        {4'd7, 3'b011, 4'h0, 4'h0},
        {4'd7, 3'b000, 4'h0, 4'h0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] lock_bits = 3'b000;
    logic       ext_access_pin = 1'b1;
    logic [3:0] req = 4'h0;
    logic       g_tab, g_prog, g_ver, g_exec, ea;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prog_lock_ctrl uut (
        .clk              (clk),
        .rst              (rst),
        .lock_bits        (lock_bits),
        .ext_access_pin   (ext_access_pin),
        .req_table_read   (req[0]),
        .req_program      (req[1]),
        .req_verify       (req[2]),
        .req_ext_exec     (req[3]),
        .grant_table_read (g_tab),
        .grant_program    (g_prog),
        .grant_verify     (g_ver),
        .grant_ext_exec   (g_exec),
        .ea_effective     (ea)
    );

    function automatic string tag(input int id);
        case (id)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string name, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", name, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst = 1'b1;
        ext_access_pin = pin;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state, all bits blank: live pin, no grants (R1, R7)
        do_reset(1'b1);
        #1;
        check("R1 reset ea follows pin", {3'b0, ea}, 4'h1);
        check("R7 reset no grants", {g_exec, g_ver, g_prog, g_tab}, 4'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            lock_bits = VEC[i][10:8];
            req = VEC[i][7:4];
            #1;
            check($sformatf("%s grant vector %0d", tag(int'(VEC[i][14:11])), i),
                  {g_exec, g_ver, g_prog, g_tab}, VEC[i][3:0]);
        end

        // R1: live pin passes through in the same cycle
        @(negedge clk);
        lock_bits = 3'b000;
        ext_access_pin = 1'b0;
        #1;
        check("R1 live pin low", {3'b0, ea}, 4'h0);
        ext_access_pin = 1'b1;
        #1;
        check("R1 live pin high", {3'b0, ea}, 4'h1);

        // R3: reset with pin low, lock set; pin toggles ignored
        lock_bits = 3'b001;
        do_reset(1'b0);
        ext_access_pin = 1'b1;
        #1;
        check("R3 latched low, pin high", {3'b0, ea}, 4'h0);
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R3 latched low after cycles", {3'b0, ea}, 4'h0);
        lock_bits = 3'b010;
        #1;
        check("R3 latched under bit1 only", {3'b0, ea}, 4'h0);

        // R8: second reset with pin high recaptures
        lock_bits = 3'b111;
        do_reset(1'b1);
        ext_access_pin = 1'b0;
        #1;
        check("R8 recaptured high, pin low", {3'b0, ea}, 4'h1);
        @(negedge clk);
        #1;
        check("R8 held after a cycle", {3'b0, ea}, 4'h1);

        // Unlock: back to the live pin
        lock_bits = 3'b000;
        #1;
        check("R1 unlocked follows live pin", {3'b0, ea}, 4'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule